// File: doc/BRIEF.md
# Legacy PCI interrupt routing matrix

This block carries level-sensitive interrupt requests from the functions of several PCI devices to the sixteen inputs of a legacy 8259-style interrupt controller. Routing passes through three programmable stages. First, each of a device's eight functions is steered onto one of that device's four INTx pins, or onto none. Second, each device's four pins are steered onto eight shared PIRQ lines, A to H. Third, each PIRQ line is steered to one legacy IRQ number, or left unrouted.

Requests share freely at every stage. Several functions on one pin, several pins on one PIRQ line and several PIRQ lines on one IRQ are all combined by OR. A separate output always carries the eight raw PIRQ levels for an APIC-side consumer.

Firmware programs all three stages through a byte-wide write port with a combinational read-back. The request path is purely combinational. Only configuration writes are registered. All signals are active-high. The block has no state machine: its only state is the configuration registers, which are written one byte per clock.

Top module: `legacy_irq_router`

## Requirements
- R1: After reset, every pin selection reads 0, every device route byte for pin p reads p, and every PIRQ routing register reads 0x80. With all requests high, `irq_req` and `pirq_level` are both 0.
- R2: The pin selection of device d, function f is written at byte address 8*d+f, in bits 2:0. Code 1 steers the function to INTA, 2 to INTB, 3 to INTC and 4 to INTD. Codes 0, 5, 6 and 7 steer it nowhere.
- R3: A device pin is active while any function that selects it is requesting.
- R4: The route of device d, pin p (0 = INTA to 3 = INTD) is held at byte address 0x40+4*d+p, in bits 2:0, as a PIRQ index from 0 (A) to 7 (H). A PIRQ line is active while any pin of any device routed to it is active.
- R5: `pirq_level[k]` shows PIRQ line k whatever its routing register holds, including when bit 7 is set.
- R6: While bit 7 of a PIRQ routing register is set, that line drives no `irq_req` bit.
- R7: With bit 7 clear, bits 3:0 name the IRQ bit that the line drives. Only IRQ 3–7, 9–12, 14 and 15 are valid targets. A line holding a reserved code (0, 1, 2, 8 or 13) drives nothing.
- R8: A PIRQ routing register reads back the full byte last written to it, reserved codes included.
- R9: When several PIRQ lines target one IRQ number, that IRQ bit is their OR.
- R10: The routing registers of PIRQ A–D sit at 0x60–0x63 and those of E–H at 0x68–0x6B. Any address outside the three maps reads 0, and a write to it changes no output.
- R11: A change of `func_req` appears on both outputs in the same cycle. A configuration write takes effect at the clock edge on which `cfg_we` is sampled high, and not before.
- R12: `irq_req` bits 0, 1, 2, 8 and 13 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_addr | input | 8 | Byte address for the write and for the read-back |
| cfg_wdata | input | 8 | Byte to be written |
| cfg_rdata | output | 8 | Combinational read-back of the byte at `cfg_addr` |
| func_req | input | NUM_DEV*8 | Level request of function f of device d at bit 8*d+f |
| pirq_level | output | 8 | Raw levels of PIRQ lines A (bit 0) to H (bit 7) |
| irq_req | output | 16 | Legacy IRQ request levels, bit n for IRQ n |

## Verification
Both outputs follow `func_req` with no register in the path. The bench therefore changes requests just after a falling edge and samples one time unit later, inside the same cycle. A configuration write is driven for one full low-to-low clock period, so the rising edge in the middle captures it. Its effect is then sampled after the following falling edge. One write check also samples the output just before the capturing edge, to confirm that nothing has changed yet. Read-back goes through the combinational `cfg_rdata` in the same way: the address is set after a falling edge and the data is sampled one time unit later.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    localparam int FUNCS = 8;
    localparam int PINS  = 4;
    localparam int PIRQS = 8;
    localparam int IRQS  = 16;

    // IRQ numbers that a PIRQ line may reach: 3-7, 9-12, 14, 15
    localparam logic [IRQS-1:0] IRQ_VALID_MASK = 16'hDEF8;

    localparam int PINSEL_BASE = 8'h00;
    localparam int ROUTE_BASE  = 8'h40;

    typedef logic [2:0] pin_code_t;
    typedef logic [2:0] pirq_idx_t;
    typedef logic [3:0] irq_code_t;
    typedef logic [7:0] rout_t;

    localparam rout_t ROUT_RESET = 8'h80;

    function automatic logic [7:0] rout_addr(input int k);
        return (k < 4) ? 8'(8'h60 + k) : 8'(8'h68 + (k - 4));
    endfunction
endpackage

// File: rtl/irqr_cfg_regs.sv
module irqr_cfg_regs
    import irqr_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [7:0]                          cfg_addr,
    input  logic [7:0]                          cfg_wdata,
    output logic [7:0]                          cfg_rdata,
    output pin_code_t [NUM_DEV*FUNCS-1:0]       pin_sel_o,
    output pirq_idx_t [NUM_DEV*PINS-1:0]        route_o,
    output logic [PIRQS-1:0]                    pirq_off_o,
    output irq_code_t [PIRQS-1:0]               irq_code_o
);
    localparam int NSEL   = NUM_DEV * FUNCS;
    localparam int NROUTE = NUM_DEV * PINS;

    pin_code_t [NSEL-1:0]   pin_sel_q;
    pirq_idx_t [NROUTE-1:0] route_q;
    rout_t     [PIRQS-1:0]  rout_q;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pin_sel_q[i] <= '0;
            else if (cfg_we && cfg_addr == 8'(PINSEL_BASE + i))
                pin_sel_q[i] <= cfg_wdata[2:0];
        end
    end

    for (genvar i = 0; i < NROUTE; i++) begin : g_route
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                route_q[i] <= 3'(i % PINS);
            else if (cfg_we && cfg_addr == 8'(ROUTE_BASE + i))
                route_q[i] <= cfg_wdata[2:0];
        end
    end

    for (genvar k = 0; k < PIRQS; k++) begin : g_rout
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rout_q[k] <= ROUT_RESET;
            else if (cfg_we && cfg_addr == rout_addr(k))
                rout_q[k] <= cfg_wdata;
        end
        assign pirq_off_o[k] = rout_q[k][7];
        assign irq_code_o[k] = rout_q[k][3:0];
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NSEL; i++)
            if (cfg_addr == 8'(PINSEL_BASE + i)) cfg_rdata = {5'b0, pin_sel_q[i]};
        for (int i = 0; i < NROUTE; i++)
            if (cfg_addr == 8'(ROUTE_BASE + i)) cfg_rdata = {5'b0, route_q[i]};
        for (int k = 0; k < PIRQS; k++)
            if (cfg_addr == rout_addr(k)) cfg_rdata = rout_q[k];
    end

    assign pin_sel_o = pin_sel_q;
    assign route_o   = route_q;
endmodule

// File: rtl/irqr_pin_stage.sv
module irqr_pin_stage
    import irqr_pkg::*;
(
    input  logic [FUNCS-1:0]      req_i,
    input  pin_code_t [FUNCS-1:0] sel_i,
    output logic [PINS-1:0]       intx_o
);
    always_comb begin
        intx_o = '0;
        for (int f = 0; f < FUNCS; f++)
            for (int p = 0; p < PINS; p++)
                if (req_i[f] && sel_i[f] == pin_code_t'(p + 1))
                    intx_o[p] = 1'b1;
    end
endmodule

// File: rtl/irqr_pirq_stage.sv
module irqr_pirq_stage
    import irqr_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic [NUM_DEV*PINS-1:0]      intx_i,
    input  pirq_idx_t [NUM_DEV*PINS-1:0] route_i,
    output logic [PIRQS-1:0]             pirq_o
);
    always_comb begin
        pirq_o = '0;
        for (int j = 0; j < NUM_DEV*PINS; j++)
            if (intx_i[j]) pirq_o[route_i[j]] = 1'b1;
    end
endmodule

// File: rtl/irqr_irq_stage.sv
module irqr_irq_stage
    import irqr_pkg::*;
(
    input  logic [PIRQS-1:0]      pirq_i,
    input  logic [PIRQS-1:0]      off_i,
    input  irq_code_t [PIRQS-1:0] code_i,
    output logic [IRQS-1:0]       irq_o
);
    logic [IRQS-1:0] raw;

    always_comb begin
        raw = '0;
        for (int k = 0; k < PIRQS; k++)
            if (pirq_i[k] && !off_i[k]) raw[code_i[k]] = 1'b1;
    end

    assign irq_o = raw & IRQ_VALID_MASK;
endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
    import irqr_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_addr,
    input  logic [7:0]               cfg_wdata,
    output logic [7:0]               cfg_rdata,
    input  logic [NUM_DEV*FUNCS-1:0] func_req,
    output logic [PIRQS-1:0]         pirq_level,
    output logic [IRQS-1:0]          irq_req
);
    pin_code_t [NUM_DEV*FUNCS-1:0] pin_sel;
    pirq_idx_t [NUM_DEV*PINS-1:0]  route;
    logic [PIRQS-1:0]              pirq_off;
    irq_code_t [PIRQS-1:0]         irq_code;
    logic [NUM_DEV*PINS-1:0]       intx;

    irqr_cfg_regs #(.NUM_DEV(NUM_DEV)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .pin_sel_o  (pin_sel),
        .route_o    (route),
        .pirq_off_o (pirq_off),
        .irq_code_o (irq_code)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        irqr_pin_stage u_pin (
            .req_i  (func_req[d*FUNCS +: FUNCS]),
            .sel_i  (pin_sel[d*FUNCS +: FUNCS]),
            .intx_o (intx[d*PINS +: PINS])
        );
    end

    irqr_pirq_stage #(.NUM_DEV(NUM_DEV)) u_pirq (
        .intx_i  (intx),
        .route_i (route),
        .pirq_o  (pirq_level)
    );

    irqr_irq_stage u_irq (
        .pirq_i (pirq_level),
        .off_i  (pirq_off),
        .code_i (irq_code),
        .irq_o  (irq_req)
    );
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
    import irqr_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [7:0]               cfg_addr,
    input logic [7:0]               cfg_wdata,
    input logic [7:0]               cfg_rdata,
    input logic [NUM_DEV*FUNCS-1:0] func_req,
    input logic [PIRQS-1:0]         pirq_level,
    input logic [IRQS-1:0]          irq_req
);
    AST_RESERVED_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~IRQ_VALID_MASK) == '0); // R12

    AST_IRQ_NEEDS_PIRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |-> (pirq_level != '0)); // R6

    AST_PIRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_level != '0) |-> (func_req != '0)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (func_req == '0) |-> (irq_req == '0 && pirq_level == '0)); // R3

    AST_ROUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg_addr == 8'h60 && $past(cfg_we) && $past(cfg_addr) == 8'h60)
        |-> (cfg_rdata == $past(cfg_wdata))); // R8

    AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr inside {[8'h64:8'h67]}) |-> (cfg_rdata == 8'h00)); // R10
endmodule

bind legacy_irq_router irqr_checker #(.NUM_DEV(NUM_DEV)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .func_req   (func_req),
    .pirq_level (pirq_level),
    .irq_req    (irq_req)
);

// File: tb/legacy_irq_router_tb_top.sv
module legacy_irq_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 4;
    localparam int NREQ = NDEV * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [NREQ-1:0] func_req = '0;
    logic [7:0] pirq_level;
    logic [15:0] irq_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [2:0] m_pin [NREQ];
    logic [2:0] m_route [NDEV*4];
    logic [7:0] m_rout [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_irq_router #(.NUM_DEV(NDEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .func_req(func_req),
        .pirq_level(pirq_level), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] a_rout(input int k);
        return (k < 4) ? 8'(8'h60 + k) : 8'(8'h68 + k - 4);
    endfunction

    function automatic bit irq_ok(input int n);
        return n inside {3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
    endfunction

    function automatic logic [7:0] exp_pirq(input logic [NREQ-1:0] r);
        logic [7:0] p = '0;
        for (int i = 0; i < NREQ; i++) begin
            int c = int'(m_pin[i]);
            if (r[i] && c >= 1 && c <= 4) p[m_route[(i/8)*4 + c - 1]] = 1'b1;
        end
        return p;
    endfunction

    function automatic logic [15:0] exp_irq(input logic [7:0] p);
        logic [15:0] q = '0;
        for (int k = 0; k < 8; k++)
            if (p[k] && !m_rout[k][7] && irq_ok(int'(m_rout[k][3:0])))
                q[m_rout[k][3:0]] = 1'b1;
        return q;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_pin(input int d, input int f, input logic [2:0] c);
        wr(8'(d*8 + f), {5'b0, c});
        m_pin[d*8 + f] = c;
    endtask

    task automatic set_route(input int d, input int p, input logic [2:0] k);
        wr(8'(8'h40 + d*4 + p), {5'b0, k});
        m_route[d*4 + p] = k;
    endtask

    task automatic set_rout(input int k, input logic [7:0] v);
        wr(a_rout(k), v);
        m_rout[k] = v;
    endtask

    task automatic drive_and_check(input logic [NREQ-1:0] r, input string tag);
        @(negedge clk);
        func_req = r;
        #1;
        chk({tag, " pirq"}, 32'(pirq_level), 32'(exp_pirq(r)));
        chk({tag, " irq"}, 32'(irq_req), 32'(exp_irq(exp_pirq(r))));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        for (int i = 0; i < NREQ; i++) m_pin[i] = 3'd0;
        for (int i = 0; i < NDEV*4; i++) m_route[i] = 3'(i % 4);
        for (int k = 0; k < 8; k++) m_rout[k] = 8'h80;

        // R1: quiet in and after reset with every request high
        func_req = '1;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq_req), 0);
        chk("R1 pirq in reset", 32'(pirq_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq_req), 0);
        for (int i = 0; i < NREQ; i++) begin
            rd(8'(i), rb);
            chk("R1 pin sel reset", 32'(rb), 0);
        end
        for (int i = 0; i < NDEV*4; i++) begin
            rd(8'(8'h40 + i), rb);
            chk("R1 route reset", 32'(rb), 32'(i % 4));
        end
        for (int k = 0; k < 8; k++) begin
            rd(a_rout(k), rb);
            chk("R1 rout reset", 32'(rb), 32'h80);
        end
        func_req = '0;

        // R2: every pin code on device 1 function 3, routed to PIRQ E..H
        for (int p = 0; p < 4; p++) set_route(1, p, 3'(p + 4));
        for (int k = 0; k < 8; k++) set_rout(k, 8'(k < 4 ? 3 + k : 9 + k - 4));
        for (int c = 0; c < 8; c++) begin
            set_pin(1, 3, 3'(c));
            drive_and_check(NREQ'(1) << 11, "R2 code sweep");
            rd(8'(11), rb);
            chk("R2 pin readback", 32'(rb), 32'(c));
        end
        set_pin(1, 3, 3'd0);

        // R5 R6 R7 R8 R12: each PIRQ line over every code, bit 7 both ways
        set_pin(0, 0, 3'd1);
        for (int k = 0; k < 8; k++) begin
            set_route(0, 0, 3'(k));
            for (int v = 0; v < 32; v++) begin
                logic [7:0] val = {v[4], 3'(v * 5), v[3:0]};
                set_rout(k, val);
                rd(a_rout(k), rb);
                chk("R8 rout readback", 32'(rb), 32'(val));
                drive_and_check(NREQ'(1), "R7 code sweep");
                chk("R5 raw level", 32'(pirq_level), 32'(1 << k));
                if (val[7]) chk("R6 unrouted", 32'(irq_req), 0);
                chk("R12 reserved low", 32'(irq_req & 16'h2107), 0);
            end
            set_rout(k, 8'h80);
        end

        // R11: write not visible before capturing edge, visible after
        set_rout(0, 8'h8B);
        set_route(0, 0, 3'd0);
        @(negedge clk);
        func_req = NREQ'(1);
        cfg_we = 1'b1; cfg_addr = 8'h60; cfg_wdata = 8'h0B;
        #1 chk("R11 before edge", 32'(irq_req), 0);
        @(negedge clk);
        cfg_we = 1'b0;
        m_rout[0] = 8'h0B;
        #1 chk("R11 after edge", 32'(irq_req), 32'h0800);
        @(negedge clk);
        func_req = '0;
        #1 chk("R11 same-cycle request", 32'(irq_req), 0);

        // R3 R4 R9: random full configurations and request patterns
        for (int round = 0; round < 30; round++) begin
            for (int i = 0; i < NREQ; i++) set_pin(i / 8, i % 8, 3'($urandom_range(0, 7)));
            for (int i = 0; i < NDEV*4; i++) set_route(i / 4, i % 4, 3'($urandom_range(0, 7)));
            for (int k = 0; k < 8; k++)
                set_rout(k, {($urandom_range(0, 3) == 0), 3'b0, 4'($urandom_range(0, 15))});
            if (round % 3 == 0) begin
                set_rout(1, 8'h05);
                set_rout(6, 8'h05);
            end
            for (int t = 0; t < 40; t++)
                drive_and_check(NREQ'($urandom), "R3 R4 R9 random");
            drive_and_check('1, "R9 all requests");
        end

        // R10: unmapped addresses read zero and change nothing
        func_req = '1;
        wr(8'h64, 8'h5A);
        rd(8'h64, rb);
        chk("R10 gap reads zero", 32'(rb), 0);
        wr(8'h20, 8'h01);
        rd(8'h20, rb);
        chk("R10 unmapped reads zero", 32'(rb), 0);
        wr(8'hFF, 8'h03);
        drive_and_check('1, "R10 outputs unchanged");
        rd(8'h6B, rb);
        chk("R10 PIRQ H offset", 32'(rb), 32'(m_rout[7]));
        rd(8'h63, rb);
        chk("R10 PIRQ D offset", 32'(rb), 32'(m_rout[3]));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule